// File: doc/BRIEF.md
# Encoder-Paced Exposure Unit Sequencer

This block walks through the exposure units of one circular track and sets the laser intensity for each unit. Unit records arrive on a valid/ready input. Each record is 16 bits: the intensity code sits in bits [7:0] and the dwell, counted in encoder pulses, sits in bits [15:8]. The block waits for the start-of-revolution index pulse before it does anything. It then puts the first unit's intensity on a registered DAC code output. The unit stays in place for as many rotary-encoder pulses as its record specifies, and after that the next record takes its place.

The encoder and index inputs are asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector. After the configured number of units, the block pulses track-done, sets the DAC code to zero and waits for the next index. The track can also run short of records. If no record is offered when a unit expires, the block sets the DAC code to zero, raises a sticky underrun flag and stops until reset.

Top module: `exposure_unit_sequencer`

## Requirements
- R1: During reset and in the first cycle after it, the DAC code is 0 and the strobe, track-done, underrun and record-ready outputs are all low.
- R2: Before the first index rising edge, encoder pulses have no effect. The DAC code stays 0, no strobe is issued and no record is accepted.
- R3: The block acts on an index rising edge while it is waiting. It takes the offered record, and the DAC code shows record bits [7:0] three clock edges after the index input rises.
- R4: Each encoder rising edge lowers the current unit's remaining count by one. On the edge that uses up the count, the next record is accepted and its code appears, again three edges after the input rises.
- R5: A dwell field of 0 in record bits [15:8] means 256 pulses.
- R6: The units-per-track input sets how many units make up a track. After the last unit expires, track-done is high for exactly one cycle, the DAC code is 0 and the block waits for the next index.
- R7: If no record is valid when the block needs one, the DAC code becomes 0 and underrun goes high. Underrun stays high, and until reset the block ignores all further index and encoder edges and accepts no records.
- R8: The DAC strobe is high for exactly one cycle after every write to the DAC code register. This includes the writes that set the code to zero at track end and at underrun.
- R9: Index edges that arrive while a track is running have no effect.
- R10: An encoder input that stays high for several clock cycles counts as one pulse. The block accepts a new pulse every second clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_pulse_i | input | 1 | Asynchronous rotary encoder pulse |
| index_i | input | 1 | Asynchronous start-of-revolution pulse |
| units_cfg_i | input | 16 | Units per track (at least 1) |
| rec_valid_i | input | 1 | Unit record offered |
| rec_data_i | input | 16 | Record: [7:0] intensity, [15:8] dwell pulses |
| rec_ready_o | output | 1 | Record accepted in this cycle when valid |
| dac_code_o | output | 8 | Registered intensity code |
| dac_stb_o | output | 1 | One-cycle update strobe |
| track_done_o | output | 1 | One-cycle track completion pulse |
| underrun_o | output | 1 | Sticky record-underrun flag |

## Verification
The latency from input to result is fixed. An index or encoder rising edge that is first sampled at clock edge k updates the DAC code, strobe, track-done and underrun at edge k+2. Record-ready is combinational and goes high in the cycle just before that edge. The reference model passes its own copies of the two inputs through a three-stage delay, makes the same decision at the same edge, and compares every output at each falling clock edge. The directed checks wait four cycles after the last input change before they read a settled value.

// File: rtl/exposure_seq_pkg.sv
// Shared types for the exposure unit sequencer.
package exposure_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_WAIT_INDEX = 2'd0,
        SEQ_RUN        = 2'd1,
        SEQ_HALTED     = 2'd2
    } seq_state_t;
endpackage

// File: rtl/async_rise_detect.sv
// Brings an asynchronous level into the clock domain through a synchronizer
// chain of SYNC_STAGES flops, then flags each rising edge for one cycle.
// Assumes the input stays high or low for at least one clock at a time.
module async_rise_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // shift the async level through the synchronizer plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], async_i};
    end

    // rising edge: synchronized level high, previous level low
    always_comb rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // R10: a single input rise never produces back-to-back edge flags
    p_single_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/dwell_counter.sv
// Down counter holding the remaining encoder pulses of the current unit.
// Loading a zero dwell field means a full 2**CNT_W pulses.
// Assumes the caller never decrements the count when it is 1; expiry at 1
// is handled by the caller.
module dwell_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             at_one_o
);
    localparam int          FULL_W = CNT_W + 1;
    localparam logic [FULL_W-1:0] FULL_CNT = FULL_W'(1) << CNT_W;

    logic [FULL_W-1:0] cnt_q;

    // load a new dwell (zero field becomes full range) or count down one pulse
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= (load_val_i == '0) ? FULL_CNT : {1'b0, load_val_i};
        else if (dec_i)  cnt_q <= cnt_q - FULL_W'(1);
    end

    // the next pulse will finish the current unit
    always_comb at_one_o = (cnt_q == FULL_W'(1));

    // R4: the caller never decrements an empty or expiring count
    p_no_dec_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q > FULL_W'(1)));
    // R5: a zero dwell field gives the full pulse range
    p_zero_dwell_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i == '0) |=> (cnt_q == FULL_CNT));
endmodule

// File: rtl/unit_tracker.sv
// Counts the units issued in the current track and reports when the current
// unit is the last one. Assumes units_cfg_i is at least 1 and does not
// change while a track is running.
module unit_tracker #(
    parameter int UNIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_i,
    input  logic              adv_i,
    input  logic [UNIT_W-1:0] units_cfg_i,
    output logic              last_o
);
    logic [UNIT_W-1:0] issued_q;

    // restart the count on a track's first unit, bump it on each later unit
    always_ff @(posedge clk) begin
        if (!rst_n)       issued_q <= '0;
        else if (first_i) issued_q <= UNIT_W'(1);
        else if (adv_i)   issued_q <= issued_q + UNIT_W'(1);
    end

    // the current unit is the final one of the track
    always_comb last_o = (issued_q >= units_cfg_i);

    // R6: no unit beyond the configured count is ever issued
    p_adv_within_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> !last_o);
endmodule

// File: rtl/exposure_unit_sequencer.sv
// Paces the exposure units of one circular track with encoder pulses.
// It waits for an index edge, then shows each record's intensity for that
// record's pulse count. It sets the code to zero at track end or when a
// record is missing; a missing record halts the block until reset.
// Assumes the record source holds its data stable while valid is high.
module exposure_unit_sequencer
    import exposure_seq_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int DWELL_W     = 8,
    parameter int UNIT_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enc_pulse_i,
    input  logic                       index_i,
    input  logic [UNIT_W-1:0]          units_cfg_i,
    input  logic                       rec_valid_i,
    input  logic [CODE_W+DWELL_W-1:0]  rec_data_i,
    output logic                       rec_ready_o,
    output logic [CODE_W-1:0]          dac_code_o,
    output logic                       dac_stb_o,
    output logic                       track_done_o,
    output logic                       underrun_o
);
    localparam int REC_W = CODE_W + DWELL_W;

    seq_state_t state_q;
    logic enc_rise, idx_rise;
    logic cnt_at_one, unit_last;
    logic first_slot, expire, next_slot, take, finish, starve;
    logic [CODE_W-1:0]  rec_code;
    logic [DWELL_W-1:0] rec_dwell;

    async_rise_detect #(.SYNC_STAGES(SYNC_STAGES)) u_enc_sync (
        .clk(clk), .rst_n(rst_n), .async_i(enc_pulse_i), .rise_o(enc_rise));

    async_rise_detect #(.SYNC_STAGES(SYNC_STAGES)) u_idx_sync (
        .clk(clk), .rst_n(rst_n), .async_i(index_i), .rise_o(idx_rise));

    // split the record into intensity and dwell fields
    always_comb begin
        rec_code  = rec_data_i[CODE_W-1:0];
        rec_dwell = rec_data_i[REC_W-1:CODE_W];
    end

    // decide this cycle's event: first unit, next unit, track end or underrun
    always_comb begin
        first_slot  = (state_q == SEQ_WAIT_INDEX) && idx_rise;
        expire      = (state_q == SEQ_RUN) && enc_rise && cnt_at_one;
        next_slot   = expire && !unit_last;
        finish      = expire && unit_last;
        rec_ready_o = first_slot || next_slot;
        take        = rec_ready_o && rec_valid_i;
        starve      = rec_ready_o && !rec_valid_i;
    end

    dwell_counter #(.CNT_W(DWELL_W)) u_dwell (
        .clk(clk), .rst_n(rst_n),
        .load_i(take), .load_val_i(rec_dwell),
        .dec_i((state_q == SEQ_RUN) && enc_rise && !cnt_at_one),
        .at_one_o(cnt_at_one));

    unit_tracker #(.UNIT_W(UNIT_W)) u_units (
        .clk(clk), .rst_n(rst_n),
        .first_i(take && (state_q == SEQ_WAIT_INDEX)),
        .adv_i(take && (state_q == SEQ_RUN)),
        .units_cfg_i(units_cfg_i),
        .last_o(unit_last));

    // sequencer state: wait for index, run the track, or halt on underrun
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_WAIT_INDEX;
        else begin
            unique case (state_q)
                SEQ_WAIT_INDEX: if (take) state_q <= SEQ_RUN;
                                else if (starve) state_q <= SEQ_HALTED;
                SEQ_RUN:        if (finish) state_q <= SEQ_WAIT_INDEX;
                                else if (starve) state_q <= SEQ_HALTED;
                default:        state_q <= SEQ_HALTED;
            endcase
        end
    end

    // register the DAC code, its strobe and the completion/underrun flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code_o   <= '0;
            dac_stb_o    <= 1'b0;
            track_done_o <= 1'b0;
            underrun_o   <= 1'b0;
        end else begin
            if (take)                 dac_code_o <= rec_code;
            else if (finish || starve) dac_code_o <= '0;
            dac_stb_o    <= take || finish || starve;
            track_done_o <= finish;
            underrun_o   <= underrun_o || starve;
        end
    end

    // R7: underrun never clears without reset
    p_sticky_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> underrun_o);
    // R7: a halted block shows zero and accepts nothing
    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> (dac_code_o == '0) && !rec_ready_o);
    // R6: track completion comes with a zero code
    p_done_zero_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        track_done_o |-> (dac_code_o == '0) && dac_stb_o);
    // R8: the code only moves in a strobed cycle
    p_code_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_stb_o |-> $stable(dac_code_o));
    // R2: records are requested only on a synchronized input edge
    p_ready_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ready_o |-> (idx_rise || enc_rise));
endmodule

// File: tb/test_exposure_unit_sequencer.sv
module test_exposure_unit_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_i = 1'b0;
    logic        idx_i = 1'b0;
    logic [15:0] units_cfg = 16'd1;
    logic        rec_valid = 1'b0;
    logic [15:0] rec_data = 16'h0;
    logic        rec_ready, dac_stb, track_done, underrun;
    logic [7:0]  dac_code;

    always #2 clk = ~clk;   // 250 MHz

    exposure_unit_sequencer i_exposure_unit_sequencer (
        .clk(clk), .rst_n(rst_n), .enc_pulse_i(enc_i), .index_i(idx_i),
        .units_cfg_i(units_cfg), .rec_valid_i(rec_valid), .rec_data_i(rec_data),
        .rec_ready_o(rec_ready), .dac_code_o(dac_code), .dac_stb_o(dac_stb),
        .track_done_o(track_done), .underrun_o(underrun));

    int checks = 0;
    int fails = 0;
    int stb_seen = 0;
    int done_seen = 0;
    logic [15:0] src_q[$];
    bit starve_src = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: inputs seen three edges late, units as a plain loop
    int m_state = 0;      // 0 waiting, 1 running, 2 halted
    int m_left = 0, m_issued = 0;
    int m_code = 0, m_stb = 0, m_done = 0, m_und = 0;
    bit e_lat[3], i_lat[3];
    bit rdy_seen = 0;

    function automatic int dwell_of(logic [15:0] r);
        return (r[15:8] == 0) ? 256 : int'(r[15:8]);
    endfunction

    always @(posedge clk) begin
        bit ie, ee;
        if (!rst_n) begin
            m_state = 0; m_left = 0; m_issued = 0;
            m_code = 0; m_stb = 0; m_done = 0; m_und = 0;
            for (int k = 0; k < 3; k++) begin e_lat[k] = 0; i_lat[k] = 0; end
        end else begin
            ie = i_lat[1] && !i_lat[2];
            ee = e_lat[1] && !e_lat[2];
            m_stb = 0; m_done = 0;
            if (m_state == 0 && ie) begin
                if (rec_valid) begin
                    m_code = rec_data[7:0]; m_left = dwell_of(rec_data);
                    m_issued = 1; m_state = 1; m_stb = 1;
                end else begin
                    m_code = 0; m_und = 1; m_state = 2; m_stb = 1;
                end
            end else if (m_state == 1 && ee) begin
                if (m_left > 1) m_left--;
                else if (m_issued >= units_cfg) begin
                    m_code = 0; m_done = 1; m_stb = 1; m_state = 0;
                end else if (rec_valid) begin
                    m_code = rec_data[7:0]; m_left = dwell_of(rec_data);
                    m_issued++; m_stb = 1;
                end else begin
                    m_code = 0; m_und = 1; m_state = 2; m_stb = 1;
                end
            end
            if (rec_valid && rdy_seen) void'(src_q.pop_front());
            i_lat[2] = i_lat[1]; i_lat[1] = i_lat[0]; i_lat[0] = idx_i;
            e_lat[2] = e_lat[1]; e_lat[1] = e_lat[0]; e_lat[0] = enc_i;
        end
    end

    // compare every output on the falling edge, then refresh the source
    always @(negedge clk) begin
        int exp_rdy;
        if (rst_n) begin
            exp_rdy = ((m_state == 0 && i_lat[1] && !i_lat[2]) ||
                       (m_state == 1 && e_lat[1] && !e_lat[2] && m_left == 1 &&
                        m_issued < units_cfg)) ? 1 : 0;
            check("R3 R4 R5 dac_code", int'(dac_code), m_code);
            check("R8 dac_stb", int'(dac_stb), m_stb);
            check("R6 track_done", int'(track_done), m_done);
            check("R7 underrun", int'(underrun), m_und);
            check("R3 rec_ready", int'(rec_ready), exp_rdy);
            if (dac_stb) stb_seen++;
            if (track_done) done_seen++;
        end
        rdy_seen  = rec_ready;
        rec_valid = (src_q.size() > 0) && !starve_src;
        rec_data  = (src_q.size() > 0) ? src_q[0] : 16'h0;
    end

    task automatic enc_pulse(int hi, int lo);
        @(negedge clk); enc_i = 1'b1;
        repeat (hi) @(negedge clk);
        enc_i = 1'b0;
        repeat (lo - 1) @(negedge clk);
    endtask

    task automatic enc_train(int n);
        for (int k = 0; k < n; k++) enc_pulse(1, 1);
    endtask

    task automatic idx_pulse();
        @(negedge clk); idx_i = 1'b1;
        @(negedge clk); idx_i = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 code", int'(dac_code), 0);
        check("R1 flags", int'({dac_stb, track_done, underrun, rec_ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'({dac_code, dac_stb, track_done, underrun, rec_ready}), 0);

        // R2: encoder pulses before any index do nothing
        units_cfg = 16'd3;
        src_q.push_back({8'd2, 8'h11});
        src_q.push_back({8'd1, 8'h22});
        src_q.push_back({8'd3, 8'h33});
        enc_train(5); settle();
        check("R2 code", int'(dac_code), 0);
        check("R2 strobes", stb_seen, 0);
        check("R2 records kept", src_q.size(), 3);

        // R3/R4: a three-unit track
        idx_pulse(); settle();
        check("R3 first code", int'(dac_code), 8'h11);
        enc_pulse(1, 1); settle();
        check("R4 mid dwell", int'(dac_code), 8'h11);
        enc_pulse(1, 1); settle();
        check("R4 second unit", int'(dac_code), 8'h22);
        idx_pulse(); settle();
        check("R9 index ignored", int'(dac_code), 8'h22);
        enc_train(1); settle();
        check("R4 third unit", int'(dac_code), 8'h33);
        enc_train(3); settle();
        check("R6 done pulses", done_seen, 1);
        check("R6 zero code", int'(dac_code), 0);
        check("R8 strobe count", stb_seen, 4);

        // R5: zero dwell field lasts 256 pulses
        units_cfg = 16'd2;
        src_q.push_back({8'd0, 8'h44});
        src_q.push_back({8'd1, 8'h55});
        idx_pulse(); settle();
        enc_train(255); settle();
        check("R5 after 255", int'(dac_code), 8'h44);
        enc_train(1); settle();
        check("R5 after 256", int'(dac_code), 8'h55);
        enc_train(1); settle();
        check("R6 second track", done_seen, 2);

        // R10: a long-held encoder level counts once
        units_cfg = 16'd1;
        src_q.push_back({8'd2, 8'h66});
        idx_pulse(); settle();
        enc_pulse(4, 2); settle();
        check("R10 held level", int'(dac_code), 8'h66);
        enc_pulse(1, 1); settle();
        check("R10 second edge", int'(dac_code), 0);
        check("R10 track end", done_seen, 3);

        // R7: underrun is sticky and freezes the block
        units_cfg = 16'd3;
        src_q.push_back({8'd1, 8'h77});
        idx_pulse(); settle();
        check("R7 first code", int'(dac_code), 8'h77);
        enc_train(1); settle();
        check("R7 flag", int'(underrun), 1);
        check("R7 zero code", int'(dac_code), 0);
        src_q.push_back({8'd1, 8'h88});
        idx_pulse(); enc_train(3); settle();
        check("R7 still halted", int'({dac_code, underrun}), 1);
        check("R7 record not taken", src_q.size(), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule